// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block sits behind a real-time-clock comparator and turns two single-cycle alarm-match strobes into host-visible status flags and one active-low interrupt line. The comparator that produces the match strobes and the serial engine that reads the status byte are outside the block. The serial engine raises a one-cycle strobe at the moment the status byte has been shifted out, and that strobe clears the flags.

The block has two modes. In level mode each alarm has a sticky flag, and the interrupt line is pulled low while any flag is set whose enable bit is also set. In pulsed mode, alarm 0 no longer touches its flag. Each alarm 0 match instead fires a one-shot low pulse on the interrupt line whose length is counted in ticks of a slow oscillator. This lets the block act as a repeating trigger without any host. In pulsed mode alarm 1 remains a flag that the host must poll, and both enable bits are ignored.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: In level mode (`pulseMode`=0) a `matchA0`/`matchA1` strobe sets `flagA0`/`flagA1` in the cycle after the strobe, whether or not that alarm's enable bit is set.
- R2: In level mode `irqN` is 0 exactly while (`flagA0` AND `enA0`) OR (`flagA1` AND `enA1`) is true, and 1 otherwise. An enable change takes effect in the same cycle.
- R3: A `statusReadDone` strobe clears both flags in the following cycle, and `irqN` then returns to 1 unless a pulse is running.
- R4: In pulsed mode (`pulseMode`=1) the enable bits and the flags never drive `irqN` low.
- R5: In pulsed mode an alarm 0 match drives `irqN` to 0 from the next cycle. `irqN` stays 0 until 1024 cycles with `oscTick`=1 have been counted, and it returns to 1 in the cycle after the 1024th tick. `flagA0` is not set by that match.
- R6: In pulsed mode an alarm 1 match still sets `flagA1`, and only a `statusReadDone` strobe clears it.
- R7: When a match strobe and `statusReadDone` occur in the same cycle, the matching flag ends up set.
- R8: An alarm 0 match that arrives while a pulse is running reloads the count, so the pulse lasts a further full 1024 ticks from that match.
- R9: A synchronous `rst` clears both flags, stops any running pulse and drives `irqN` to 1.
- R10: Setting `pulseMode` to 0 while a pulse is running ends the pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| matchA0 | input | 1 | One-cycle alarm 0 match strobe |
| matchA1 | input | 1 | One-cycle alarm 1 match strobe |
| enA0 | input | 1 | Alarm 0 interrupt enable (level mode only) |
| enA1 | input | 1 | Alarm 1 interrupt enable (level mode only) |
| pulseMode | input | 1 | 0 = level mode, 1 = pulsed mode |
| statusReadDone | input | 1 | Strobe marking completion of a status byte read |
| oscTick | input | 1 | One-cycle tick per oscillator period |
| flagA0 | output | 1 | Alarm 0 status flag |
| flagA1 | output | 1 | Alarm 1 status flag |
| irqN | output | 1 | Interrupt line, active low |

## Verification
The bench drives a match and a clearing read in the same cycle. A design that gives the clear priority would lose that alarm, and the flag would read 0. It counts the pulse to the exact tick: one tick more or less would show `irqN` at the wrong level either after tick 1023 or after tick 1024. It also re-triggers alarm 0 in the middle of a pulse. A design that ignores the re-trigger, or adds the reload to the running count, would release the line too early or too late. Finally, it sets enables and flags in pulsed mode, where a design that still gates the level interrupt would pull `irqN` low.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_ALARMS = 2;

  typedef struct packed {
    logic [NUM_ALARMS-1:0] setFlag;
    logic                  clrFlags;
    logic [NUM_ALARMS-1:0] levelMask;
    logic                  pulseLoad;
    logic                  pulseTick;
    logic                  pulseKill;
  } ctlStrobes_t;
endpackage

// File: rtl/alarm_irq_ctl.sv
module alarm_irq_ctl
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_ALARM = 0
) (
  input  logic [NUM_ALARMS-1:0] matchIn,
  input  logic [NUM_ALARMS-1:0] enIn,
  input  logic                  pulseMode,
  input  logic                  readDone,
  input  logic                  oscTick,
  output ctlStrobes_t           strb
);
  logic [NUM_ALARMS-1:0] setVec;
  logic [NUM_ALARMS-1:0] maskVec;

  // Per-alarm decode: the pulse-capable alarm loses its flag in pulsed mode.
  for (genvar i = 0; i < NUM_ALARMS; i++) begin : gAlarm
    if (i == PULSE_ALARM) begin : gPulsing
      assign setVec[i] = matchIn[i] & ~pulseMode;
    end else begin : gPolled
      assign setVec[i] = matchIn[i];
    end
    // Enables only gate the level interrupt when not in pulsed mode.
    assign maskVec[i] = enIn[i] & ~pulseMode;
  end

  always_comb begin
    strb           = '0;
    strb.setFlag   = setVec;
    strb.clrFlags  = readDone;
    strb.levelMask = maskVec;
    strb.pulseLoad = matchIn[PULSE_ALARM] & pulseMode;
    strb.pulseTick = oscTick & pulseMode;
    strb.pulseKill = ~pulseMode;
  end
endmodule

// File: rtl/alarm_irq_dp.sv
module alarm_irq_dp
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 1024,
  localparam int CNT_W = $clog2(PULSE_TICKS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctlStrobes_t           strb,
  output logic [NUM_ALARMS-1:0] flags,
  output logic                  irqN
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] pulseCnt;
  logic             pulseActive;
  logic             levelIrq;

  // Sticky flags: set wins over clear.
  for (genvar i = 0; i < NUM_ALARMS; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (rst)                    flags[i] <= 1'b0;
      else if (strb.setFlag[i])   flags[i] <= 1'b1;
      else if (strb.clrFlags)     flags[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      strb.setFlag[i] |=> flags[i]); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (strb.clrFlags && !strb.setFlag[i]) |=> !flags[i]); // R3
  end

  // One-shot pulse counter, counted in oscillator ticks.
  always_ff @(posedge clk) begin
    if (rst)                                 pulseCnt <= '0;
    else if (strb.pulseKill)                 pulseCnt <= '0;
    else if (strb.pulseLoad)                 pulseCnt <= LOAD_VAL;
    else if (strb.pulseTick && pulseActive)  pulseCnt <= pulseCnt - CNT_W'(1);
  end

  assign pulseActive = (pulseCnt != '0);
  assign levelIrq    = |(flags & strb.levelMask);
  assign irqN        = ~(levelIrq | pulseActive);

  AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    strb.pulseLoad |=> (pulseCnt == LOAD_VAL)); // R8
  AST_PULSE_STEP: assert property (@(posedge clk) disable iff (rst)
    (strb.pulseTick && !strb.pulseLoad && !strb.pulseKill && pulseActive)
      |=> (pulseCnt == $past(pulseCnt) - CNT_W'(1))); // R5
  AST_PULSE_KILL: assert property (@(posedge clk) disable iff (rst)
    strb.pulseKill |=> !pulseActive); // R10
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic matchA0,
  input  logic matchA1,
  input  logic enA0,
  input  logic enA1,
  input  logic pulseMode,
  input  logic statusReadDone,
  input  logic oscTick,
  output logic flagA0,
  output logic flagA1,
  output logic irqN
);
  ctlStrobes_t           strb;
  logic [NUM_ALARMS-1:0] flagVec;

  alarm_irq_ctl #(.PULSE_ALARM(0)) uCtl (
    .matchIn  ({matchA1, matchA0}),
    .enIn     ({enA1, enA0}),
    .pulseMode(pulseMode),
    .readDone (statusReadDone),
    .oscTick  (oscTick),
    .strb     (strb)
  );

  alarm_irq_dp #(.PULSE_TICKS(PULSE_TICKS)) uDp (
    .clk  (clk),
    .rst  (rst),
    .strb (strb),
    .flags(flagVec),
    .irqN (irqN)
  );

  assign flagA0 = flagVec[0];
  assign flagA1 = flagVec[1];

  AST_NO_FLAG0_PULSED: assert property (@(posedge clk) disable iff (rst)
    (pulseMode && !flagA0) |=> !flagA0); // R5
  AST_FLAG1_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    matchA1 |=> flagA1); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!flagA0 && !flagA1 && irqN)); // R9
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic matchA0 = 0, matchA1 = 0, enA0 = 0, enA1 = 0;
  logic pulseMode = 0, statusReadDone = 0, oscTick = 0;
  logic flagA0, flagA1, irqN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  alarm_irq_ctrl dut (
    .clk(clk), .rst(rst), .matchA0(matchA0), .matchA1(matchA1),
    .enA0(enA0), .enA1(enA1), .pulseMode(pulseMode),
    .statusReadDone(statusReadDone), .oscTick(oscTick),
    .flagA0(flagA0), .flagA1(flagA1), .irqN(irqN)
  );

  // Vector: {m0, m1, e0, e1, mode, rd, expF0, expF1, expIrqN}
  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    9'b100000_101, // R1 match0, enable off: flag only
    9'b001000_100, // R2 enable on: irq low
    9'b010100_110, // R2 flag1 with en1
    9'b001101_001, // R3 read clears both
    9'b100001_101, // R7 set beats clear
    9'b001000_100, // R2 level irq from flag0
    9'b001110_101, // R4 pulsed mode masks level irq
    9'b010110_111, // R6 alarm1 flag, no irq
    9'b000011_001  // R6 read clears polled flag
  };

  task automatic chk(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    matchA0 = 0; matchA1 = 0; statusReadDone = 0; oscTick = 0;
  endtask

  task automatic ticks(int n);
    oscTick = 1;
    for (int k = 0; k < n; k++) step();
    oscTick = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(); step();
    rst = 0;
    chk("R9", flagA0, 1'b0, "flagA0 after reset");
    chk("R9", flagA1, 1'b0, "flagA1 after reset");
    chk("R9", irqN, 1'b1, "irqN after reset");

    for (int v = 0; v < NV; v++) begin
      {matchA0, matchA1, enA0, enA1, pulseMode, statusReadDone} = VEC[v][8:3];
      step();
      chk($sformatf("vec%0d", v), flagA0, VEC[v][2], "flagA0");
      chk($sformatf("vec%0d", v), flagA1, VEC[v][1], "flagA1");
      chk($sformatf("vec%0d", v), irqN,   VEC[v][0], "irqN");
    end
    idle();

    // R5 pulse length
    pulseMode = 1; enA0 = 0; enA1 = 0;
    matchA0 = 1; step(); matchA0 = 0;
    chk("R5", irqN, 1'b0, "irqN at pulse start");
    chk("R5", flagA0, 1'b0, "flagA0 in pulsed mode");
    ticks(1023);
    chk("R5", irqN, 1'b0, "irqN after 1023 ticks");
    ticks(1);
    chk("R5", irqN, 1'b1, "irqN after 1024 ticks");

    // R8 restart mid-pulse
    matchA0 = 1; step(); matchA0 = 0;
    ticks(500);
    matchA0 = 1; step(); matchA0 = 0;
    ticks(1023);
    chk("R8", irqN, 1'b0, "irqN 1023 ticks after retrigger");
    ticks(1);
    chk("R8", irqN, 1'b1, "irqN 1024 ticks after retrigger");

    // R4 enables ignored even with flag and enable set
    matchA1 = 1; enA1 = 1; enA0 = 1; step(); matchA1 = 0;
    chk("R4", irqN, 1'b1, "irqN with flag1 and en1 in pulsed mode");
    statusReadDone = 1; step(); statusReadDone = 0;
    enA0 = 0; enA1 = 0;

    // R10 leaving pulsed mode ends pulse
    matchA0 = 1; step(); matchA0 = 0;
    ticks(10);
    chk("R10", irqN, 1'b0, "irqN mid pulse");
    pulseMode = 0; step();
    chk("R10", irqN, 1'b1, "irqN after mode exit");

    // R9 reset with flag set and pulse running
    pulseMode = 1;
    matchA1 = 1; step(); matchA1 = 0;
    matchA0 = 1; step(); matchA0 = 0;
    chk("R9", irqN, 1'b0, "irqN pulse before reset");
    rst = 1; step(); rst = 0;
    chk("R9", flagA1, 1'b0, "flagA1 after mid-run reset");
    chk("R9", irqN, 1'b1, "irqN after mid-run reset");
    step();
    chk("R9", irqN, 1'b1, "pulse stays stopped after reset");

    finish_run();
  end
endmodule